// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers eight interrupt sources of a CAN-style bus controller into one active-low interrupt line and a 3-bit code. The code names the most urgent source that is both flagged and enabled. Hardware event pulses set the flags. The sources are receive buffer full (two buffers), transmit buffer empty (three buffers), bus-activity wakeup, error-state change and message error. The host can read and write a source-enable register and a flag register through a simple register port.

A write may be plain, which loads all eight bits, or masked, where only the bits chosen by a mask take the new data. The masked form lets software acknowledge one flag without overwriting a flag that hardware sets in the same cycle. While a source's underlying condition is still present (its hold input is high), the host cannot clear that flag. The host can also set a flag by writing a 1, which raises an interrupt just as a hardware event would. The protocol engine, the message buffers and the serial host link sit outside this block.

Top module: `ifc_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable and flag registers read 0x00, `irq_n` is 1 and `irq_code` is 000.
- R2: A plain write with `wr_sel`=0 loads all eight bits of the enable register. A masked write (`wr_bitmod`=1) changes only the bits set in `wr_mask`. Reads with `rd_sel`=0 return the enable register.
- R3: A pulse on `evt_set[i]` sets flag bit i at the next clock edge. The bit map is: 7 message error, 6 wakeup, 5 error, 4 TX2 empty, 3 TX1 empty, 2 TX0 empty, 1 RX1 full, 0 RX0 full. The enable register uses the same map, and reads with `rd_sel`=1 return the flag register.
- R4: `irq_n` is 0 exactly when at least one flag bit and its enable bit are both 1, and 1 otherwise.
- R5: A host write of 1 to a flag bit (`wr_sel`=1) sets that flag. If the bit is enabled, the interrupt rises as it would for a hardware event.
- R6: A host write of 0 to a flag bit whose `evt_hold` bit is 1 leaves the flag unchanged.
- R7: A masked write to the flag register changes only the bits set in `wr_mask`. Every other flag keeps its value or takes a hardware set from the same cycle.
- R8: When a hardware set and a host clear hit the same flag in the same cycle, the flag ends up 1.
- R9: `irq_code` uses this encoding: 000 none, 001 error, 010 wakeup, 011 TX0, 100 TX1, 101 TX2, 110 RX0, 111 RX1. When several sources are pending, the lowest nonzero code wins.
- R10: Only flags whose enable bit is set count toward the code. A pending message-error flag pulls `irq_n` low but never appears in the code.
- R11: When the highest-priority pending flag is cleared, `irq_code` moves to the next pending enabled source, or to 000 if none is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 enable register, 1 flag register |
| wr_bitmod | input | 1 | 1 = masked write through `wr_mask`, 0 = plain write |
| wr_mask | input | 8 | Bit select for a masked write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 enable register, 1 flag register |
| rd_data | output | 8 | Read data of the selected register |
| evt_set | input | 8 | Hardware set pulses, one per source |
| evt_hold | input | 8 | Source condition still present; blocks a host clear |
| irq_n | output | 1 | Interrupt request, active low |
| irq_code | output | 3 | Code of the highest-priority pending enabled source |

## Verification
The assertions assume that every input is driven to a known value on every clock edge after reset. They also assume `wr_mask` is ignored unless `wr_bitmod` is high. They make no assumption about how long `evt_hold` stays high or how often `evt_set` pulses.

The stimulus drives every port at each falling edge. It keeps `evt_hold` high in streaks so that host clears often collide with a present condition. It fires `evt_set` sparsely so that several sources become pending together. Directed steps force the set-versus-clear collision, a masked acknowledge that races a hardware set, and a pending message-error flag with no coded source enabled.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    localparam int NSRC   = 8;
    localparam int CODE_W = 3;

    // flag / enable bit positions (decoded by software and by the encoder)
    localparam int BIT_RX0  = 0;
    localparam int BIT_RX1  = 1;
    localparam int BIT_TX0  = 2;
    localparam int BIT_TX1  = 3;
    localparam int BIT_TX2  = 4;
    localparam int BIT_ERR  = 5;
    localparam int BIT_WAKE = 6;
    localparam int BIT_MERR = 7;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE = 3'd0,
        CODE_ERR  = 3'd1,
        CODE_WAKE = 3'd2,
        CODE_TX0  = 3'd3,
        CODE_TX1  = 3'd4,
        CODE_TX2  = 3'd5,
        CODE_RX0  = 3'd6,
        CODE_RX1  = 3'd7
    } code_t;

    typedef struct packed {
        logic     en_hit;
        logic     fl_hit;
        src_vec_t mask;
        src_vec_t data;
    } host_wr_t;

    // lowest code value = highest priority; message error is never coded
    function automatic code_t prio_code(input src_vec_t pend);
        code_t c;
        if      (pend[BIT_ERR])  c = CODE_ERR;
        else if (pend[BIT_WAKE]) c = CODE_WAKE;
        else if (pend[BIT_TX0])  c = CODE_TX0;
        else if (pend[BIT_TX1])  c = CODE_TX1;
        else if (pend[BIT_TX2])  c = CODE_TX2;
        else if (pend[BIT_RX0])  c = CODE_RX0;
        else if (pend[BIT_RX1])  c = CODE_RX1;
        else                     c = CODE_NONE;
        return c;
    endfunction

endpackage

// File: rtl/ifc_wr_decode.sv
module ifc_wr_decode
    import ifc_pkg::*;
(
    input  logic     wr_en,
    input  logic     wr_sel,
    input  logic     wr_bitmod,
    input  src_vec_t wr_mask,
    input  src_vec_t wr_data,
    output host_wr_t hw_o
);
    always_comb begin
        hw_o.en_hit = wr_en && !wr_sel;
        hw_o.fl_hit = wr_en &&  wr_sel;
        hw_o.mask   = wr_bitmod ? wr_mask : '1;
        hw_o.data   = wr_data;
    end
endmodule

// File: rtl/ifc_enable_reg.sv
module ifc_enable_reg
    import ifc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hit,
    input  src_vec_t mask,
    input  src_vec_t data,
    output src_vec_t en_q
);
    always_ff @(posedge clk) begin
        if (rst)      en_q <= '0;
        else if (hit) en_q <= (en_q & ~mask) | (data & mask);
    end

    AST_EN_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
        hit |=> ((en_q ^ $past(en_q)) & ~$past(mask)) == '0); // R2
    AST_EN_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
        !hit |=> en_q == $past(en_q)); // R2
endmodule

// File: rtl/ifc_flag_cell.sv
module ifc_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic hold,
    input  logic wr_hit,
    input  logic wr_val,
    output logic q
);
    logic q_nx;

    always_comb begin
        q_nx = q;
        if (wr_hit) begin
            if (wr_val)     q_nx = 1'b1;
            else if (!hold) q_nx = 1'b0;
        end
        if (set_evt) q_nx = 1'b1;   // hardware set wins over a clear
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q_nx;
    end
endmodule

// File: rtl/ifc_flag_bank.sv
module ifc_flag_bank
    import ifc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hit,
    input  src_vec_t mask,
    input  src_vec_t data,
    input  src_vec_t evt_set,
    input  src_vec_t evt_hold,
    output src_vec_t fl_q
);
    src_vec_t cell_hit;
    assign cell_hit = hit ? mask : '0;

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        ifc_flag_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_evt (evt_set[i]),
            .hold    (evt_hold[i]),
            .wr_hit  (cell_hit[i]),
            .wr_val  (data[i]),
            .q       (fl_q[i])
        );
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|evt_set) |=> (fl_q & $past(evt_set)) == $past(evt_set)); // R3
    AST_HOLD_BLOCKS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (|(fl_q & evt_hold)) |=> (fl_q & $past(fl_q & evt_hold)) == $past(fl_q & evt_hold)); // R6
    AST_MASK_ONLY: assert property (@(posedge clk) disable iff (rst)
        hit |=> ((fl_q ^ $past(fl_q)) & ~$past(mask) & ~$past(evt_set)) == '0); // R7
    AST_HOST_SET: assert property (@(posedge clk) disable iff (rst)
        hit |=> (fl_q & $past(mask & data)) == $past(mask & data)); // R5
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst)
        !hit |=> (fl_q & ~$past(fl_q) & ~$past(evt_set)) == '0); // R3
endmodule

// File: rtl/ifc_prio_enc.sv
module ifc_prio_enc
    import ifc_pkg::*;
(
    input  src_vec_t flags,
    input  src_vec_t enables,
    output logic     irq_n,
    output code_t    code
);
    src_vec_t pend;

    always_comb begin
        pend  = flags & enables;
        irq_n = ~(|pend);
        code  = prio_code(pend);
    end

    always_comb begin
        if (code != CODE_NONE) AST_CODE_NEEDS_IRQ: assert (!irq_n); // R9
        if (irq_n) AST_IDLE_NO_CODE: assert (code == CODE_NONE); // R4
    end
endmodule

// File: rtl/ifc_irq_ctrl.sv
module ifc_irq_ctrl
    import ifc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic                  wr_bitmod,
    input  logic [NSRC-1:0]       wr_mask,
    input  logic [NSRC-1:0]       wr_data,
    input  logic                  rd_sel,
    output logic [NSRC-1:0]       rd_data,
    input  logic [NSRC-1:0]       evt_set,
    input  logic [NSRC-1:0]       evt_hold,
    output logic                  irq_n,
    output logic [CODE_W-1:0]     irq_code
);
    host_wr_t wr;
    src_vec_t en_q;
    src_vec_t fl_q;
    code_t    code;

    ifc_wr_decode u_dec (
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_bitmod (wr_bitmod),
        .wr_mask   (wr_mask),
        .wr_data   (wr_data),
        .hw_o      (wr)
    );

    ifc_enable_reg u_en (
        .clk  (clk),
        .rst  (rst),
        .hit  (wr.en_hit),
        .mask (wr.mask),
        .data (wr.data),
        .en_q (en_q)
    );

    ifc_flag_bank u_fl (
        .clk      (clk),
        .rst      (rst),
        .hit      (wr.fl_hit),
        .mask     (wr.mask),
        .data     (wr.data),
        .evt_set  (evt_set),
        .evt_hold (evt_hold),
        .fl_q     (fl_q)
    );

    ifc_prio_enc u_enc (
        .flags   (fl_q),
        .enables (en_q),
        .irq_n   (irq_n),
        .code    (code)
    );

    assign irq_code = code;
    assign rd_data  = rd_sel ? fl_q : en_q;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (irq_n && irq_code == 3'd0)); // R1
    AST_SET_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && (|(evt_set & wr_mask & ~wr_data))) |=> !(|($past(evt_set) & ~fl_q))); // R8
    AST_MERR_UNCODED: assert property (@(posedge clk) disable iff (rst)
        (en_q == 8'h80 && fl_q[BIT_MERR]) |-> (!irq_n && irq_code == 3'd0)); // R10
endmodule

// File: tb/ifc_irq_ctrl_tb.sv
module ifc_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0, wr_bitmod = 1'b0, rd_sel = 1'b0;
    logic [7:0] wr_mask = '0, wr_data = '0, evt_set = '0, evt_hold = '0;
    logic [7:0] rd_data;
    logic       irq_n;
    logic [2:0] irq_code;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] m_en = '0;
    logic [7:0] m_fl = '0;

    always #4 clk = ~clk;

    ifc_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_bitmod(wr_bitmod),
        .wr_mask(wr_mask), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .evt_set(evt_set), .evt_hold(evt_hold), .irq_n(irq_n), .irq_code(irq_code)
    );

    // priority list, most urgent first, as bit positions (R9)
    function automatic logic [2:0] exp_code(input logic [7:0] pend);
        int order [7] = '{5, 6, 2, 3, 4, 0, 1};
        logic [2:0] c = 3'd0;
        for (int k = 6; k >= 0; k--)
            if (pend[order[k]]) c = 3'(k + 1);
        return c;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "irq_n (R4)", {7'd0, irq_n}, {7'd0, ~|(m_fl & m_en)});
        cmp(tag, "irq_code (R9 R10 R11)", {5'd0, irq_code}, {5'd0, exp_code(m_fl & m_en)});
        cmp(tag, "rd_data (R2 R3)", rd_data, rd_sel ? m_fl : m_en);
    endtask

    task automatic step(input logic we, input logic sel, input logic bm, input logic [7:0] msk,
                        input logic [7:0] dat, input logic [7:0] ev, input logic [7:0] hd,
                        input logic rs, input string tag);
        logic [7:0] em, clr, st;
        wr_en = we; wr_sel = sel; wr_bitmod = bm; wr_mask = msk; wr_data = dat;
        evt_set = ev; evt_hold = hd; rd_sel = rs;
        @(posedge clk);
        em  = bm ? msk : 8'hFF;
        if (we && !sel) m_en = (m_en & ~em) | (dat & em);
        clr = (we && sel) ? (em & ~dat & ~hd) : 8'h00;
        st  = (we && sel) ? (em & dat) : 8'h00;
        m_fl = (m_fl & ~clr) | st | ev;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] hold_r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd_sel = 1'b0; #1 check_all("R1 enable");
        rd_sel = 1'b1; #1 check_all("R1 flags");

        step(1, 0, 0, 8'h00, 8'hFF, 8'h00, 8'h00, 0, "R2 plain enable write");
        step(1, 0, 1, 8'h0F, 8'h00, 8'h00, 8'h00, 0, "R2 masked enable write");
        step(1, 0, 0, 8'h00, 8'hFF, 8'h00, 8'h00, 1, "R2 restore enables");
        step(0, 0, 0, 8'h00, 8'h00, 8'h04, 8'h00, 1, "R3 TX0 event");
        step(1, 1, 0, 8'h00, 8'h24, 8'h00, 8'h00, 1, "R5 host sets error flag");
        step(1, 1, 1, 8'h20, 8'h00, 8'h00, 8'h00, 1, "R11 ack error, code to TX0");
        step(1, 1, 1, 8'h04, 8'h00, 8'h00, 8'h04, 1, "R6 clear blocked by hold");
        step(1, 1, 1, 8'h01, 8'h00, 8'h01, 8'h00, 1, "R8 set beats clear");
        step(1, 1, 1, 8'h02, 8'h02, 8'h40, 8'h00, 1, "R7 masked write with wake event");
        step(1, 1, 1, 8'h40, 8'h00, 8'h00, 8'h00, 1, "R11 ack wakeup");
        step(1, 1, 0, 8'h00, 8'h80, 8'h00, 8'h00, 1, "R10 only message error");
        step(1, 0, 0, 8'h00, 8'h80, 8'h00, 8'h00, 1, "R10 only merr enabled");
        step(1, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, 1, "R10 nothing enabled");
        step(1, 0, 0, 8'h00, 8'hFF, 8'h00, 8'h00, 1, "R4 re-enable all");
        step(1, 1, 0, 8'h00, 8'h00, 8'h00, 8'h00, 1, "R4 clear all flags");

        hold_r = '0;
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] ev;
            logic we, sel, bm;
            if ($urandom_range(0, 7) == 0) hold_r = 8'($urandom);
            ev  = 8'($urandom) & 8'($urandom) & 8'($urandom);
            we  = ($urandom_range(0, 2) != 0);
            sel = ($urandom_range(0, 3) != 0);
            bm  = $urandom_range(0, 1) == 1;
            step(we, sel, bm, 8'($urandom), 8'($urandom) & 8'($urandom), ev, hold_r,
                 $urandom_range(0, 1) == 1, "RND R3 R5 R6 R7 R8");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule